// File: doc/BRIEF.md
# Configurable-Associativity Read Cache

This block sits between a processor load port and a slower byte-wide backing memory. It holds four two-byte lines and answers 5-bit byte-addressed loads. The `WAYS` parameter builds it as a direct-mapped cache (`WAYS=1`), a two-way set-associative cache (`WAYS=2`) or a fully associative cache (`WAYS=4`). Capacity stays the same in all three, so only the split of the address between tag and index changes.

A load is handed over with a valid/ready handshake. The block then compares the tag with every valid way of the selected set.

- **Hit:** the addressed byte comes back one cycle later.
- **Miss:** the block raises `stall` and drops `req_ready`. It clears the chosen victim line and reads the whole block from backing memory, lowest byte first, one request/valid beat per byte. When the last beat arrives it marks the line valid and returns the requested byte.

In the associative builds, the way that is replaced is taken from the `victim_sel` input, so a replacement policy outside the block decides. In the direct-mapped build `victim_sel` has no effect.

Top module: `cfg_assoc_cache`

## Requirements
- R1: After reset `req_ready` is 1, and `stall`, `resp_valid`, `mem_req`, `hit_count` and `miss_count` are 0. Every line is invalid, so the first load of any block is a miss.
- R2: With `WAYS=1`, the tag is `addr[4:3]`, the line index is `addr[2:1]` and the byte offset is `addr[0]`. A miss always replaces the indexed line, whatever `victim_sel` holds.
- R3: With `WAYS=2`, the tag is `addr[4:2]` and the set is `addr[1]`; lines 2·set and 2·set+1 form the set. A miss replaces the way given by `victim_sel[0]`.
- R4: With `WAYS=4`, the tag is `addr[4:1]` and there is no index. Any block may occupy any line, and a miss replaces line `victim_sel[1:0]`.
- R5: A load whose tag matches a valid way of its set is a hit. In the cycle after acceptance `resp_valid` is 1 for one cycle, with `resp_data` equal to the byte at offset `addr[0]`. `stall` and `mem_req` stay 0.
- R6: Starting in the cycle after a miss is accepted:
  - `stall` is 1 and `req_ready` is 0.
  - `mem_req` is 1, with `mem_addr` = {`addr[4:1]`,0} and then {`addr[4:1]`,1}.
  - A beat is taken in a cycle where `mem_req` and `mem_valid` are both 1.
  - While `mem_valid` is 0, `mem_req` and `mem_addr` hold.
- R7: In the cycle after the second beat:
  - `resp_valid` is 1 with the requested byte.
  - `stall` is 0 and `req_ready` is 1.
  - The line is valid, so later loads of either byte of that block hit.
- R8: `hit_count` and `miss_count` each go up by one for every accepted hit and every accepted miss respectively.
- R9: After a replacement, the evicted block misses on its next load, while the other lines, including the other ways of the same set, keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| victim_sel | input | WAY_W | Way to replace on a miss (unused when WAYS=1) |
| req_ready | output | 1 | Block can accept a load |
| resp_valid | output | 1 | Load data valid, one cycle |
| resp_data | output | DATA_W | Returned byte |
| stall | output | 1 | Refill in progress |
| mem_req | output | 1 | Backing-memory read request |
| mem_addr | output | ADDR_W | Byte address being read from backing memory |
| mem_valid | input | 1 | Backing memory returns `mem_data` this cycle |
| mem_data | input | DATA_W | Byte from backing memory |
| hit_count | output | CNT_W | Accepted hits since reset |
| miss_count | output | CNT_W | Accepted misses since reset |

## Verification
A hit response is due exactly one clock after the accepting edge. The bench drives each load at a falling edge and samples `resp_valid`, `resp_data` and both counters at the next falling edge.

A miss shows `stall`, `mem_req` and the offset-0 `mem_addr` at that same next falling edge. The bench then inserts 0 to 2 idle cycles before each beat, checking at every falling edge that the request and address hold. It expects the offset to advance one edge after the first beat and the byte to be returned one edge after the second.

All three builds run the same kind of directed sequences, with hit or miss decided in advance from the address split. That makes conflict evictions, victim steering and the direct-mapped independence from `victim_sel` visible at the ports.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  typedef enum logic [0:0] {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cache_addr_split.sv
`timescale 1ns/1ps
module cache_addr_split #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 1,
  parameter int TAG_W  = 3,
  parameter int SET_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [SET_W-1:0]  set_idx,
  output logic [OFF_W-1:0]  off
);
  assign off = addr[OFF_W-1:0];
  assign tag = addr[ADDR_W-1 -: TAG_W];

  generate
    if (IDX_W > 0) begin : g_indexed
      assign set_idx = addr[OFF_W +: SET_W];
    end else begin : g_no_index
      assign set_idx = '0;
    end
  endgenerate
endmodule

// File: rtl/cache_tag_match.sv
`timescale 1ns/1ps
module cache_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 3,
  parameter int WAY_W = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  // one comparator per way, all in parallel
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_valid[w] && (way_tags[w] == tag);
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  // a block may live in at most one way of its set
  assert_unique_tag_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/cache_fill_fsm.sv
`timescale 1ns/1ps
module cache_fill_fsm
  import cache_pkg::*;
#(
  parameter int BLOCK_BYTES = 2,
  parameter int OFF_W       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mem_valid,
  output logic             busy,
  output logic             mem_req,
  output logic [OFF_W-1:0] fill_off,
  output logic             beat,
  output logic             last_beat
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLOCK_BYTES - 1);

  fill_state_e      state_q;
  logic [OFF_W-1:0] off_q;

  assign busy      = (state_q == FILL_BUSY);
  assign mem_req   = busy;
  assign fill_off  = off_q;
  assign beat      = busy && mem_valid;
  assign last_beat = beat && (off_q == LAST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FILL_IDLE;
      off_q   <= '0;
    end else begin
      case (state_q)
        FILL_IDLE: begin
          if (start) begin
            state_q <= FILL_BUSY;
            off_q   <= '0;
          end
        end
        FILL_BUSY: begin
          if (last_beat) begin
            state_q <= FILL_IDLE;
            off_q   <= '0;
          end else if (beat) begin
            off_q <= off_q + OFF_W'(1);
          end
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  // request and offset hold while memory has not answered
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_valid) |=> (busy && $stable(off_q)));

  // the refill ends right after its final beat
  assert_fill_ends_R7: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> !busy);
endmodule

// File: rtl/cfg_assoc_cache.sv
`timescale 1ns/1ps
module cfg_assoc_cache #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int LINES       = 4,
  parameter int BLOCK_BYTES = 2,
  parameter int WAYS        = 2,
  parameter int CNT_W       = 16,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WAY_W-1:0]  victim_sel,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int SETS   = LINES / WAYS;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int SET_W  = (SETS > 1) ? IDX_W : 1;
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int BYTES  = LINES * BLOCK_BYTES;

  function automatic logic [LINE_W-1:0] line_of(input logic [SET_W-1:0] s,
                                                input logic [WAY_W-1:0] w);
    int n;
    n = ((SETS > 1) ? int'(s) : 0) * WAYS + ((WAYS > 1) ? int'(w) : 0);
    return LINE_W'(n);
  endfunction

  // line storage
  logic [LINES-1:0]  line_valid_q;
  logic [TAG_W-1:0]  line_tag_q  [LINES];
  logic [DATA_W-1:0] line_data_q [BYTES];

  // request address fields
  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] req_set;
  logic [OFF_W-1:0] req_off;

  cache_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SET_W(SET_W)
  ) u_split (
    .addr(req_addr), .tag(req_tag), .set_idx(req_set), .off(req_off)
  );

  // gather the ways of the selected set
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_valid;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_gather
      localparam logic [WAY_W-1:0] WIDX = WAY_W'(w);
      assign set_tags[w]  = line_tag_q[line_of(req_set, WIDX)];
      assign set_valid[w] = line_valid_q[line_of(req_set, WIDX)];
    end
  endgenerate

  logic             lookup_hit;
  logic [WAY_W-1:0] hit_way;

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .clk(clk), .rst(rst),
    .way_tags(set_tags), .way_valid(set_valid), .tag(req_tag),
    .hit(lookup_hit), .hit_way(hit_way)
  );

  // victim: fixed by index when direct-mapped, external otherwise
  logic [WAY_W-1:0] victim_way;
  generate
    if (WAYS > 1) begin : g_victim_ext
      assign victim_way = victim_sel;
    end else begin : g_victim_fixed
      assign victim_way = '0;
    end
  endgenerate

  logic [LINE_W-1:0] hit_line, victim_line;
  assign hit_line    = line_of(req_set, hit_way);
  assign victim_line = line_of(req_set, victim_way);

  // refill sequencing
  logic             busy, fill_beat, fill_last;
  logic [OFF_W-1:0] fill_off;
  logic             accept, hit_accept, miss_start;

  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign hit_accept = accept && lookup_hit;
  assign miss_start = accept && !lookup_hit;

  cache_fill_fsm #(.BLOCK_BYTES(BLOCK_BYTES), .OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst(rst), .start(miss_start), .mem_valid(mem_valid),
    .busy(busy), .mem_req(mem_req), .fill_off(fill_off),
    .beat(fill_beat), .last_beat(fill_last)
  );

  logic [ADDR_W-1:0] miss_addr_q;
  logic [LINE_W-1:0] fill_line_q;
  logic [OFF_W-1:0]  miss_off;

  assign miss_off = miss_addr_q[OFF_W-1:0];
  assign mem_addr = {miss_addr_q[ADDR_W-1:OFF_W], fill_off};
  assign stall    = busy;

  // control state with reset
  logic             resp_valid_q;
  logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_valid_q <= '0;
      miss_addr_q  <= '0;
      fill_line_q  <= '0;
      resp_valid_q <= 1'b0;
      hit_cnt_q    <= '0;
      miss_cnt_q   <= '0;
    end else begin
      resp_valid_q <= hit_accept || fill_last;
      if (hit_accept) hit_cnt_q <= hit_cnt_q + CNT_W'(1);
      if (miss_start) begin
        miss_cnt_q                <= miss_cnt_q + CNT_W'(1);
        miss_addr_q               <= req_addr;
        fill_line_q               <= victim_line;
        line_valid_q[victim_line] <= 1'b0;
      end
      if (fill_last) line_valid_q[fill_line_q] <= 1'b1;
    end
  end

  // tag and data arrays: plain single-write storage, no reset
  logic [DATA_W-1:0] resp_data_q;

  always_ff @(posedge clk) begin
    if (miss_start) line_tag_q[victim_line] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (fill_beat) line_data_q[{fill_line_q, fill_off}] <= mem_data;
    if (hit_accept) begin
      resp_data_q <= line_data_q[{hit_line, req_off}];
    end else if (fill_last) begin
      resp_data_q <= (miss_off == fill_off) ? mem_data
                                            : line_data_q[{fill_line_q, miss_off}];
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_data  = resp_data_q;
  assign hit_count  = hit_cnt_q;
  assign miss_count = miss_cnt_q;

  // the line under refill is never visible as valid
  assert_victim_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    stall |-> !line_valid_q[fill_line_q]);

  // a response follows either an accepted load or the final refill beat
  assert_resp_source_R5: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_valid && req_ready) || $past(mem_valid && stall)));

  // counters only ever step by one
  assert_hit_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (hit_count != $past(hit_count)))
      |-> (hit_count == $past(hit_count) + CNT_W'(1)));

  assert_miss_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (miss_count != $past(miss_count)))
      |-> (miss_count == $past(miss_count) + CNT_W'(1)));
endmodule

// File: tb/cfg_assoc_cache_bench.sv
`timescale 1ns/1ps
module cfg_assoc_cache_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  // lane 0: two-way, lane 1: direct-mapped, lane 2: fully associative
  logic        req_valid_l  [3];
  logic [4:0]  req_addr_l   [3];
  logic [1:0]  vsel_l       [3];
  logic        mem_valid_l  [3];
  logic [7:0]  mem_data_l   [3];
  logic        req_ready_l  [3];
  logic        resp_valid_l [3];
  logic [7:0]  resp_data_l  [3];
  logic        stall_l      [3];
  logic        mem_req_l    [3];
  logic [4:0]  mem_addr_l   [3];
  logic [15:0] hit_l        [3];
  logic [15:0] miss_l       [3];

  int n_checks = 0;
  int n_fail   = 0;
  int exp_hit  [3];
  int exp_miss [3];

  cfg_assoc_cache #(.WAYS(2)) u_cfg_assoc_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid_l[0]), .req_addr(req_addr_l[0]),
    .victim_sel(vsel_l[0][0:0]), .req_ready(req_ready_l[0]),
    .resp_valid(resp_valid_l[0]), .resp_data(resp_data_l[0]), .stall(stall_l[0]),
    .mem_req(mem_req_l[0]), .mem_addr(mem_addr_l[0]), .mem_valid(mem_valid_l[0]),
    .mem_data(mem_data_l[0]), .hit_count(hit_l[0]), .miss_count(miss_l[0]));

  cfg_assoc_cache #(.WAYS(1)) u_cfg_assoc_cache_dm (
    .clk(clk), .rst(rst), .req_valid(req_valid_l[1]), .req_addr(req_addr_l[1]),
    .victim_sel(vsel_l[1][0:0]), .req_ready(req_ready_l[1]),
    .resp_valid(resp_valid_l[1]), .resp_data(resp_data_l[1]), .stall(stall_l[1]),
    .mem_req(mem_req_l[1]), .mem_addr(mem_addr_l[1]), .mem_valid(mem_valid_l[1]),
    .mem_data(mem_data_l[1]), .hit_count(hit_l[1]), .miss_count(miss_l[1]));

  cfg_assoc_cache #(.WAYS(4)) u_cfg_assoc_cache_fa (
    .clk(clk), .rst(rst), .req_valid(req_valid_l[2]), .req_addr(req_addr_l[2]),
    .victim_sel(vsel_l[2]), .req_ready(req_ready_l[2]),
    .resp_valid(resp_valid_l[2]), .resp_data(resp_data_l[2]), .stall(stall_l[2]),
    .mem_req(mem_req_l[2]), .mem_addr(mem_addr_l[2]), .mem_valid(mem_valid_l[2]),
    .mem_data(mem_data_l[2]), .hit_count(hit_l[2]), .miss_count(miss_l[2]));

  function automatic logic [7:0] mem_byte(input logic [4:0] a);
    return 8'((int'(a) * 10 + 100) % 256);
  endfunction

  task automatic check_eq(input string rq, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one load on one lane; memory answers each beat after 'gap' idle cycles
  task automatic do_load(input int ln, input logic [4:0] a, input logic [1:0] v,
                         input bit exp_is_hit, input string rq, input int gap);
    logic [4:0] ba;
    @(negedge clk);
    check_eq(rq, "req_ready before load", int'(req_ready_l[ln]), 1);
    req_valid_l[ln] = 1'b1;
    req_addr_l[ln]  = a;
    vsel_l[ln]      = v;
    @(negedge clk);
    req_valid_l[ln] = 1'b0;
    if (exp_is_hit) begin
      exp_hit[ln]++;
      check_eq({rq, " R5"}, "hit resp_valid", int'(resp_valid_l[ln]), 1);
      check_eq({rq, " R5"}, "hit resp_data", int'(resp_data_l[ln]), int'(mem_byte(a)));
      check_eq({rq, " R5"}, "hit stall", int'(stall_l[ln]), 0);
      check_eq({rq, " R5"}, "hit mem_req", int'(mem_req_l[ln]), 0);
    end else begin
      exp_miss[ln]++;
      check_eq({rq, " R6"}, "miss stall", int'(stall_l[ln]), 1);
      check_eq({rq, " R6"}, "miss req_ready", int'(req_ready_l[ln]), 0);
      check_eq({rq, " R6"}, "miss resp_valid", int'(resp_valid_l[ln]), 0);
      for (int b = 0; b < 2; b++) begin
        ba = {a[4:1], 1'(b)};
        check_eq({rq, " R6"}, "mem_req", int'(mem_req_l[ln]), 1);
        check_eq({rq, " R6"}, "mem_addr", int'(mem_addr_l[ln]), int'(ba));
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          check_eq({rq, " R6"}, "mem_req held", int'(mem_req_l[ln]), 1);
          check_eq({rq, " R6"}, "mem_addr held", int'(mem_addr_l[ln]), int'(ba));
        end
        mem_valid_l[ln] = 1'b1;
        mem_data_l[ln]  = mem_byte(ba);
        @(negedge clk);
        mem_valid_l[ln] = 1'b0;
        mem_data_l[ln]  = 8'h00;
        if (b == 0) begin
          check_eq({rq, " R6"}, "stall mid refill", int'(stall_l[ln]), 1);
          check_eq({rq, " R6"}, "resp_valid mid refill", int'(resp_valid_l[ln]), 0);
        end
      end
      check_eq({rq, " R7"}, "refill resp_valid", int'(resp_valid_l[ln]), 1);
      check_eq({rq, " R7"}, "refill resp_data", int'(resp_data_l[ln]), int'(mem_byte(a)));
      check_eq({rq, " R7"}, "refill stall", int'(stall_l[ln]), 0);
      check_eq({rq, " R7"}, "refill req_ready", int'(req_ready_l[ln]), 1);
    end
    check_eq({rq, " R8"}, "hit_count", int'(hit_l[ln]), exp_hit[ln]);
    check_eq({rq, " R8"}, "miss_count", int'(miss_l[ln]), exp_miss[ln]);
  endtask

  task automatic test_reset();
    for (int ln = 0; ln < 3; ln++) begin
      check_eq("R1", "req_ready", int'(req_ready_l[ln]), 1);
      check_eq("R1", "stall", int'(stall_l[ln]), 0);
      check_eq("R1", "resp_valid", int'(resp_valid_l[ln]), 0);
      check_eq("R1", "mem_req", int'(mem_req_l[ln]), 0);
      check_eq("R1", "hit_count", int'(hit_l[ln]), 0);
      check_eq("R1", "miss_count", int'(miss_l[ln]), 0);
    end
  endtask

  task automatic test_cold_refill();
    do_load(0, 5'd1, 2'd0, 1'b0, "R1 cold", 1);
    do_load(0, 5'd0, 2'd0, 1'b1, "R7 same block", 0);
    do_load(0, 5'd1, 2'd0, 1'b1, "R5 offset 1", 0);
  endtask

  task automatic test_two_way();
    do_load(0, 5'd5,  2'd1, 1'b0, "R3 second way", 0);
    do_load(0, 5'd1,  2'd0, 1'b1, "R3 way0 kept", 0);
    do_load(0, 5'd4,  2'd0, 1'b1, "R3 way1", 0);
    do_load(0, 5'd12, 2'd0, 1'b0, "R9 replace way0", 2);
    do_load(0, 5'd5,  2'd0, 1'b1, "R9 other way kept", 0);
    do_load(0, 5'd13, 2'd0, 1'b1, "R5 new block", 0);
    do_load(0, 5'd1,  2'd1, 1'b0, "R9 evicted misses", 1);
    do_load(0, 5'd4,  2'd0, 1'b0, "R9 evicted way1 block", 0);
    do_load(0, 5'd1,  2'd0, 1'b1, "R9 survivor", 0);
    do_load(0, 5'd2,  2'd0, 1'b0, "R3 set1", 0);
    do_load(0, 5'd3,  2'd0, 1'b1, "R3 set1 hit", 0);
    do_load(0, 5'd0,  2'd0, 1'b1, "R3 set0 unaffected", 0);
  endtask

  task automatic test_direct_mapped();
    do_load(1, 5'd1,  2'd1, 1'b0, "R2 cold idx0", 0);
    do_load(1, 5'd5,  2'd0, 1'b0, "R2 cold idx2", 1);
    do_load(1, 5'd1,  2'd0, 1'b1, "R2 idx0 hit", 0);
    do_load(1, 5'd4,  2'd1, 1'b1, "R2 idx2 hit", 0);
    do_load(1, 5'd0,  2'd0, 1'b1, "R2 idx0 byte0", 0);
    do_load(1, 5'd12, 2'd1, 1'b0, "R2 conflict victim_sel ignored", 2);
    do_load(1, 5'd5,  2'd1, 1'b0, "R2 conflict evicted", 0);
    do_load(1, 5'd0,  2'd1, 1'b1, "R2 other line intact", 0);
    do_load(1, 5'd12, 2'd0, 1'b0, "R9 thrash", 0);
    do_load(1, 5'd24, 2'd1, 1'b0, "R2 tag bits 4:3", 1);
    do_load(1, 5'd0,  2'd0, 1'b0, "R9 evicted by tag", 0);
    do_load(1, 5'd2,  2'd0, 1'b0, "R2 idx1", 0);
    do_load(1, 5'd3,  2'd0, 1'b1, "R2 idx1 hit", 0);
  endtask

  task automatic test_fully_assoc();
    do_load(2, 5'd1,  2'd0, 1'b0, "R4 line0", 0);
    do_load(2, 5'd5,  2'd1, 1'b0, "R4 line1", 1);
    do_load(2, 5'd1,  2'd0, 1'b1, "R4 hit", 0);
    do_load(2, 5'd4,  2'd0, 1'b1, "R4 hit", 0);
    do_load(2, 5'd12, 2'd2, 1'b0, "R4 line2", 0);
    do_load(2, 5'd5,  2'd0, 1'b1, "R4 no conflict", 0);
    do_load(2, 5'd12, 2'd0, 1'b1, "R4 no conflict", 0);
    do_load(2, 5'd8,  2'd3, 1'b0, "R4 line3", 2);
    do_load(2, 5'd20, 2'd0, 1'b0, "R4 victim line0", 0);
    do_load(2, 5'd0,  2'd2, 1'b0, "R9 evicted block0", 0);
    do_load(2, 5'd4,  2'd0, 1'b1, "R9 line1 kept", 0);
    do_load(2, 5'd8,  2'd0, 1'b1, "R9 line3 kept", 0);
    do_load(2, 5'd21, 2'd0, 1'b1, "R4 line0 byte1", 0);
    do_load(2, 5'd12, 2'd3, 1'b0, "R9 evicted block12", 1);
  endtask

  initial begin
    for (int ln = 0; ln < 3; ln++) begin
      req_valid_l[ln] = 1'b0;
      req_addr_l[ln]  = '0;
      vsel_l[ln]      = '0;
      mem_valid_l[ln] = 1'b0;
      mem_data_l[ln]  = '0;
      exp_hit[ln]     = 0;
      exp_miss[ln]    = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_cold_refill();
    test_two_way();
    test_direct_mapped();
    test_fully_assoc();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule